// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches the synchronized input levels of several 32-pin GPIO banks and turns selected pin activity into a single interrupt request. Each pin has its own trigger setting, built from three configuration bits: an edge/level select, an active-level select, and a both-edges select. When a pin's trigger condition is met, a sticky pending bit is set. Software clears that bit by writing a 1 to it.

A per-pin mask decides which pending bits reach the interrupt line. Software never writes the mask directly. One write address clears mask bits (unmasks the pin), another sets them (masks the pin), and a read-only address returns the current mask. A driver can therefore change one pin without a read-modify-write sequence. The interrupt output is the OR, across all banks, of the pending bits whose mask bit is clear.

Register access is a plain 32-bit write port and a separate combinational read port. Bank `b` occupies a 0x40-byte window starting at 0x200 + 0x40·b. A field's offset inside the window selects the field.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, every mask bit reads 1. The pending, edge-select, level-select and both-edges registers read 0, and `irq` is low.
- R2: A pin with edge-select 1, both-edges 0 and level-select 1 sets its pending bit when its input goes from 0 to 1. A 1-to-0 transition does not set it.
- R3: A pin with edge-select 1, both-edges 0 and level-select 0 sets its pending bit on a 1-to-0 input transition only.
- R4: A pin with edge-select 1 and both-edges 1 sets its pending bit on either transition, whatever its level-select bit holds.
- R5: A pin with edge-select 0 sets its pending bit on every clock in which its input equals its level-select bit. The both-edges bit has no effect in this mode. Clearing the bit while the level persists does not keep it clear.
- R6: Writing to window offset 0x10 clears the mask bit of every pin written as 1. Writing to offset 0x14 sets the mask bit of every pin written as 1. Bits written as 0 leave the mask unchanged. Offset 0x0C reads back the mask, where 1 means masked. Writing 0xFFFFFFFF to offset 0x14 masks the whole bank.
- R7: Writing to window offset 0x18 clears each pending bit written as 1 and leaves each bit written as 0 unchanged. Offset 0x18 reads back the pending bits.
- R8: If a trigger event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly when some bank has a pending bit whose mask bit is 0.
- R10: Offsets 0x1C, 0x20 and 0x24 hold the edge-select, level-select and both-edges bits, which are writable and readable. Offsets 0x10 and 0x14 read as 0. Writes to 0x0C are ignored, and every address outside the bank windows reads 0.
- R11: An edge is found by comparing the input sampled at a clock edge with the input sampled one clock earlier. The resulting pending bit is visible from that clock edge on, and a steady input raises no further edge events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_sync | input | NUM_BANKS*PINS | Synchronized pin levels; bank b is slice [b*PINS +: PINS] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `pin_sync` is already synchronous to `clk` and changes only between clock edges. They also assume that reset is held long enough for every register to settle to its reset value. The bench meets both conditions: it drives pins and writes on the falling edge, and it holds reset for several cycles with all pins low. The mask and pending assertions assume that a bit changes only because of a write strobe or a trigger hit. The random phase respects this, because it only ever writes through the bus and never forces state.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Field selected by the low address bits inside one bank window.
  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_MASK_RD,   // read-only mask view
    FLD_UNMASK,    // write 1 to unmask
    FLD_MASK_SET,  // write 1 to mask
    FLD_PEND,      // pending bits, write 1 to clear
    FLD_KIND,      // 1 = edge, 0 = level
    FLD_LEVEL,     // active level / edge direction
    FLD_BOTH       // both edges when edge sensing
  } fld_e;

  function automatic logic in_window(input logic [31:0] addr, input logic [31:0] base,
                                     input logic [31:0] banks, input logic [31:0] stride);
    return (addr >= base) && (addr < base + banks * stride);
  endfunction

  function automatic logic [31:0] bank_of(input logic [31:0] addr, input logic [31:0] base,
                                          input logic [31:0] stride);
    return (addr - base) / stride;
  endfunction

  function automatic fld_e field_of(input logic [31:0] addr, input logic [31:0] base,
                                    input logic [31:0] stride);
    logic [31:0] ofs;
    ofs = (addr - base) % stride;
    case (ofs)
      32'h0C:  return FLD_MASK_RD;
      32'h10:  return FLD_UNMASK;
      32'h14:  return FLD_MASK_SET;
      32'h18:  return FLD_PEND;
      32'h1C:  return FLD_KIND;
      32'h20:  return FLD_LEVEL;
      32'h24:  return FLD_BOTH;
      default: return FLD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin,
  input  logic [PINS-1:0] kind,
  input  logic [PINS-1:0] lvl,
  input  logic [PINS-1:0] both,
  output logic [PINS-1:0] hit
);

  logic [PINS-1:0] prev;
  logic [PINS-1:0] rise;
  logic [PINS-1:0] fall;

  // Per-pin trigger decision from the mode bits and the two samples.
  function automatic logic sense(input logic k, input logic l, input logic b,
                                 input logic r, input logic f, input logic cur);
    if (!k)     return cur == l;
    else if (b) return r | f;
    else        return l ? r : f;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= pin;
  end

  assign rise = pin & ~prev;
  assign fall = ~pin & prev;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign hit[i] = sense(kind[i], lvl[i], both[i], rise[i], fall[i], pin[i]);
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin,
  input  logic            sel,
  input  fld_e            wr_fld,
  input  logic [PINS-1:0] wr_val,
  input  fld_e            rd_fld,
  output logic [PINS-1:0] rd_val,
  output logic [PINS-1:0] pend_o,
  output logic [PINS-1:0] msk_o,
  output logic [PINS-1:0] hit_o,
  output logic [PINS-1:0] clr_o,
  output logic [PINS-1:0] unm_o,
  output logic [PINS-1:0] mset_o
);

  logic [PINS-1:0] pend, msk, kind, lvl, both, hit;

  assign clr_o  = (sel && wr_fld == FLD_PEND)     ? wr_val : '0;
  assign unm_o  = (sel && wr_fld == FLD_UNMASK)   ? wr_val : '0;
  assign mset_o = (sel && wr_fld == FLD_MASK_SET) ? wr_val : '0;

  gpio_irq_trigger #(.PINS(PINS)) u_trig (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin),
    .kind (kind),
    .lvl  (lvl),
    .both (both),
    .hit  (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      msk  <= '1;
      kind <= '0;
      lvl  <= '0;
      both <= '0;
    end else begin
      // a fresh event outranks a same-cycle clear
      pend <= (pend & ~clr_o) | hit;
      msk  <= (msk & ~unm_o) | mset_o;
      if (sel && wr_fld == FLD_KIND)  kind <= wr_val;
      if (sel && wr_fld == FLD_LEVEL) lvl  <= wr_val;
      if (sel && wr_fld == FLD_BOTH)  both <= wr_val;
    end
  end

  always_comb begin
    case (rd_fld)
      FLD_MASK_RD: rd_val = msk;
      FLD_PEND:    rd_val = pend;
      FLD_KIND:    rd_val = kind;
      FLD_LEVEL:   rd_val = lvl;
      FLD_BOTH:    rd_val = both;
      default:     rd_val = '0;
    endcase
  end

  assign pend_o = pend;
  assign msk_o  = msk;
  assign hit_o  = hit;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned BANK_BASE   = 32'h200,
  parameter int unsigned BANK_STRIDE = 32'h40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_BANKS*PINS-1:0] pin_sync,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [31:0]               wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [31:0]               rd_data,
  output logic                      irq
);

  localparam int unsigned TOTAL = NUM_BANKS * PINS;

  fld_e        wr_fld, rd_fld;
  logic [31:0] wr_bank, rd_bank;
  logic        wr_in, rd_in;

  always_comb begin
    wr_in   = in_window(32'(wr_addr), BANK_BASE, NUM_BANKS, BANK_STRIDE);
    rd_in   = in_window(32'(rd_addr), BANK_BASE, NUM_BANKS, BANK_STRIDE);
    wr_bank = bank_of(32'(wr_addr), BANK_BASE, BANK_STRIDE);
    rd_bank = bank_of(32'(rd_addr), BANK_BASE, BANK_STRIDE);
    wr_fld  = field_of(32'(wr_addr), BANK_BASE, BANK_STRIDE);
    rd_fld  = field_of(32'(rd_addr), BANK_BASE, BANK_STRIDE);
  end

  // Flattened per-pin views, named for the checker.
  logic [TOTAL-1:0] pend_all, msk_all, hit_all, clr_all, unm_all, mset_all;
  logic [PINS-1:0]  rd_part [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_req;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic            sel;
    logic [PINS-1:0] rd_val;
    assign sel = wr_en && wr_in && (wr_bank == 32'(b));

    gpio_irq_bank #(.PINS(PINS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (pin_sync[b*PINS +: PINS]),
      .sel   (sel),
      .wr_fld(wr_fld),
      .wr_val(wr_data[PINS-1:0]),
      .rd_fld(rd_fld),
      .rd_val(rd_val),
      .pend_o(pend_all[b*PINS +: PINS]),
      .msk_o (msk_all[b*PINS +: PINS]),
      .hit_o (hit_all[b*PINS +: PINS]),
      .clr_o (clr_all[b*PINS +: PINS]),
      .unm_o (unm_all[b*PINS +: PINS]),
      .mset_o(mset_all[b*PINS +: PINS])
    );

    assign rd_part[b]  = (rd_in && rd_bank == 32'(b)) ? rd_val : '0;
    assign bank_req[b] = |(pend_all[b*PINS +: PINS] & ~msk_all[b*PINS +: PINS]);
  end

  always_comb begin
    logic [PINS-1:0] acc;
    acc = '0;
    for (int b = 0; b < NUM_BANKS; b++) acc |= rd_part[b];
    rd_data = 32'(acc);
  end

  assign irq = |bank_req;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic [W-1:0] pend_all,
  input logic [W-1:0] msk_all,
  input logic [W-1:0] hit_all,
  input logic [W-1:0] clr_all,
  input logic [W-1:0] unm_all,
  input logic [W-1:0] mset_all
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: first sampled cycle after reset shows the reset image
  a_r1_reset_image: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> ((&msk_all) && (pend_all == '0) && !irq));

  // R8: any hit is pending in the next cycle, clear or not
  a_r8_hit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((pend_all & $past(hit_all)) == $past(hit_all)));

  // R7: a pending bit only drops where a 1 was written to clear it
  a_r7_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(pend_all) & ~pend_all & ~$past(clr_all)) == '0));

  // R6: mask bits move only under an unmask or mask-set write
  a_r6_mask_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((($past(msk_all) ^ msk_all) & ~($past(unm_all) | $past(mset_all))) == '0));

  // R9: an asserted request needs some pending bit and some open mask bit
  a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_all != '0) && !(&msk_all)));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.W(NUM_BANKS * PINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .pend_all(pend_all),
  .msk_all (msk_all),
  .hit_all (hit_all),
  .clr_all (clr_all),
  .unm_all (unm_all),
  .mset_all(mset_all)
);

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  localparam int NB = 4;
  localparam int NP = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NB*NP-1:0] pins = '0;
  logic             wr_en = 1'b0;
  logic [9:0]       wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic [9:0]       rd_addr = '0;
  logic [31:0]      rd_data;
  logic             irq;

  always #10 clk = ~clk;  // 50 MHz

  gpio_irq_detect u0 (
    .clk(clk), .rst_n(rst_n), .pin_sync(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] m_pend[NB], m_msk[NB], m_kind[NB], m_lvl[NB], m_both[NB], m_prev[NB];

  // Trigger rule per pin, written as a table on {edge, both, level}.
  function automatic logic [31:0] events(input logic [31:0] k, input logic [31:0] l,
                                         input logic [31:0] b, input logic [31:0] cur,
                                         input logic [31:0] prv);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      case ({k[i], b[i], l[i]})
        3'b100:         r[i] = prv[i] & ~cur[i];
        3'b101:         r[i] = ~prv[i] & cur[i];
        3'b110, 3'b111: r[i] = prv[i] ^ cur[i];
        default:        r[i] = (cur[i] == l[i]);
      endcase
    end
    return r;
  endfunction

  function automatic logic [9:0] adr(input int bank, input int ofs);
    return 10'(32'h200 + bank * 32'h40 + ofs);
  endfunction

  function automatic logic [31:0] m_read(input logic [9:0] a);
    int ai;
    int b;
    ai = int'(a);
    if (ai < 'h200 || ai >= 'h300) return 32'h0;
    b = (ai - 'h200) >> 6;
    case (ai & 'h3F)
      'h0C:    return m_msk[b];
      'h18:    return m_pend[b];
      'h1C:    return m_kind[b];
      'h20:    return m_lvl[b];
      'h24:    return m_both[b];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_irq();
    logic r;
    r = 1'b0;
    for (int b = 0; b < NB; b++) r |= |(m_pend[b] & ~m_msk[b]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one cycle of stimulus and advance the model to the state after the next edge.
  task automatic apply(input logic [NB*NP-1:0] np, input bit we, input logic [9:0] wa,
                       input logic [31:0] wd);
    pins = np; wr_en = we; wr_addr = wa; wr_data = wd;
    for (int b = 0; b < NB; b++) begin
      logic [31:0] h, clr;
      h = events(m_kind[b], m_lvl[b], m_both[b], np[b*NP +: NP], m_prev[b]);
      m_prev[b] = np[b*NP +: NP];
      clr = '0;
      if (we && int'(wa) >= 'h200 + b * 'h40 && int'(wa) < 'h240 + b * 'h40) begin
        case (int'(wa) & 'h3F)
          'h10: m_msk[b] = m_msk[b] & ~wd;
          'h14: m_msk[b] = m_msk[b] | wd;
          'h18: clr = wd;
          'h1C: m_kind[b] = wd;
          'h20: m_lvl[b] = wd;
          'h24: m_both[b] = wd;
          default: ;
        endcase
      end
      m_pend[b] = (m_pend[b] & ~clr) | h;
    end
  endtask

  task automatic cyc(input logic [NB*NP-1:0] np, input bit we, input logic [9:0] wa,
                     input logic [31:0] wd, input logic [9:0] ra, input string tag);
    @(negedge clk);
    rd_addr = ra;
    #2;
    check({tag, " read"}, rd_data, m_read(ra));
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq()});
    apply(np, we, wa, wd);
  endtask

  logic [NB*NP-1:0] cp;

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [9:0] ra, input string tag);
    cyc(cp, 1'b1, a, d, ra, tag);
  endtask

  task automatic idle(input logic [9:0] ra, input string tag);
    cyc(cp, 1'b0, '0, '0, ra, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin
      m_pend[b] = '0; m_msk[b] = '1; m_kind[b] = '0;
      m_lvl[b] = '0; m_both[b] = '0; m_prev[b] = '0;
    end
    cp = '0;
    repeat (3) @(negedge clk);
    // R1 reset image while reset is held
    for (int b = 0; b < NB; b++) begin
      rd_addr = adr(b, 'h0C); #1 check("R1 mask", rd_data, 32'hFFFFFFFF);
      rd_addr = adr(b, 'h18); #1 check("R1 pend", rd_data, 32'h0);
      rd_addr = adr(b, 'h1C); #1 check("R1 kind", rd_data, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    apply(cp, 1'b0, '0, '0);

    // bank 1, pin 3 (overall bit 35) directed cases
    wr(adr(1, 'h1C), 32'hFFFFFFFF, adr(0, 'h0C), "R1");
    wr(adr(1, 'h20), 32'hFFFFFFFF, adr(1, 'h1C), "R10");
    wr(adr(1, 'h24), 32'h0, adr(1, 'h20), "R10");
    wr(adr(1, 'h18), 32'hFFFFFFFF, adr(1, 'h24), "R10");
    idle(adr(1, 'h18), "R7");
    cp[35] = 1'b1; idle(adr(1, 'h18), "R11");
    idle(adr(1, 'h18), "R2");
    idle(adr(1, 'h18), "R11");
    wr(adr(1, 'h10), 32'h8, adr(1, 'h0C), "R9");
    idle(adr(1, 'h0C), "R6");
    wr(adr(1, 'h10), 32'h0, adr(1, 'h0C), "R9");
    wr(adr(1, 'h18), 32'h0, adr(1, 'h0C), "R6");
    idle(adr(1, 'h18), "R7");
    cp[35] = 1'b0; wr(adr(1, 'h18), 32'h8, adr(1, 'h18), "R2");
    idle(adr(1, 'h18), "R2");
    cp[35] = 1'b1; wr(adr(1, 'h18), 32'h8, adr(1, 'h18), "R8");
    idle(adr(1, 'h18), "R8");
    wr(adr(1, 'h20), 32'h0, adr(1, 'h18), "R9");
    wr(adr(1, 'h18), 32'h8, adr(1, 'h18), "R3");
    cp[35] = 1'b0; idle(adr(1, 'h18), "R3");
    idle(adr(1, 'h18), "R3");
    wr(adr(1, 'h24), 32'hFFFFFFFF, adr(1, 'h18), "R4");
    wr(adr(1, 'h18), 32'h8, adr(1, 'h18), "R4");
    cp[35] = 1'b1; idle(adr(1, 'h18), "R4");
    wr(adr(1, 'h18), 32'h8, adr(1, 'h18), "R4");
    cp[35] = 1'b0; idle(adr(1, 'h18), "R4");
    wr(adr(1, 'h20), 32'hFFFFFFFF, adr(1, 'h18), "R4");
    wr(adr(1, 'h18), 32'h8, adr(1, 'h18), "R4");
    cp[35] = 1'b1; idle(adr(1, 'h18), "R4");
    wr(adr(1, 'h1C), 32'h0, adr(1, 'h18), "R4");
    wr(adr(1, 'h18), 32'h8, adr(1, 'h18), "R5");
    idle(adr(1, 'h18), "R5");
    cp[35] = 1'b0; wr(adr(1, 'h18), 32'h8, adr(1, 'h18), "R5");
    wr(adr(1, 'h18), 32'h8, adr(1, 'h18), "R5");
    idle(adr(1, 'h18), "R5");
    wr(adr(1, 'h14), 32'hFFFFFFFF, adr(1, 'h18), "R9");
    idle(adr(1, 'h0C), "R6");
    wr(adr(2, 'h0C), 32'h0, adr(1, 'h10), "R10");
    idle(adr(2, 'h0C), "R10");
    idle(10'h100, "R10");
    idle(adr(3, 'h14), "R10");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] wa, ra;
      logic [31:0] wd;
      bit we;
      int ofs[7] = '{'h0C, 'h10, 'h14, 'h18, 'h1C, 'h20, 'h24};
      for (int b = 0; b < NB; b++) cp[b*NP +: NP] ^= $urandom & $urandom & $urandom;
      we = ($urandom % 5) < 2;
      wa = adr($urandom % NB, ofs[$urandom % 7]);
      wd = ($urandom % 3 == 0) ? 32'hFFFFFFFF : $urandom;
      ra = ($urandom % 16 == 0) ? 10'($urandom % 1024) : adr($urandom % NB, ofs[$urandom % 7]);
      cyc(cp, we, wa, wd, ra, "R9/R10 random");
    end
    idle(adr(0, 'h18), "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule